// File: doc/BRIEF.md
# Routable Interrupt Controller with Software-Raised Sources

This block gathers a set of interrupt sources and steers each of them onto one of a small number of processor interrupt lines. Every source owns a configuration word that holds an enable flag, a line selector and a stored thread tag. A pending bitmap records which sources have fired. Software reads it through one register, sets bits in it through a second and clears bits through a third. In both write registers only the bits written as one take effect.

The lower sources are wired to hardware inputs and latch on a rising edge. The upper sources have no input pin; only a software write to the set register raises them, which suits signalling between processors. A line is driven while any enabled, pending source selects it. Software clears the pending bit once the event has been serviced.

The register bus is a single-cycle, byte-addressed port. Bits [2:0] of the address are ignored. Writes take effect on the rising clock edge. Read data is combinational from the current address. The pending bitmap must fit in the 64-bit data word, so `NUM_SRC` must not exceed 64.

Top module: `irq_router`

## Requirements
- R1: After reset every configuration word reads zero, the pending bitmap reads zero and all `irq_out` lines are low.
- R2: The configuration word of source s sits at byte address 8*s. Its line selector is bits [3:0], its thread tag is bits [30:8] and its enable is bit 31. All other bits read back as zero, so writing all ones reads back 0x00000000FFFFFF0F.
- R3: A read of address 8*NUM_SRC (0x100 by default) returns the pending bitmap in bits [NUM_SRC-1:0], with bit i for source i.
- R4: A write to address 8*NUM_SRC+8 (0x108) makes pending every source whose data bit is one, from the next cycle. Data bits that are zero leave their sources unchanged.
- R5: A write to address 8*NUM_SRC+16 (0x110) un-pends every source whose data bit is one. Data bits that are zero leave their sources unchanged. With no such write, a pending bit stays set.
- R6: A rising edge on `hw_irq[i]` makes source i pending from the next cycle. The bit stays set after the input falls. An input held high does not re-pend a source after it has been cleared.
- R7: If a hardware rising edge and a clear of the same source arrive in the same cycle, the source stays pending.
- R8: Sources NUM_HW and above become pending only through a write to the set register.
- R9: `irq_out[l]` is high exactly when at least one source is pending, enabled and has a selector equal to l. The line follows the register state with no extra delay.
- R10: A disabled source never drives a line. A selector value of NUM_LINES or more (5 to 15 by default) drives no line.
- R11: The thread tag is stored and read back unchanged and has no effect on routing.
- R12: Writes to the pending-read address, or to any address above the clear register, change no configuration word and no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NUM_HW | Hardware interrupt inputs, synchronous to clk, rising-edge sensitive |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address; bits [2:0] ignored |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq_out | output | NUM_LINES | Processor interrupt lines |

## Verification
A corrupted enable or selector shows at once on `irq_out`. The wrong line rises, or the expected line stays low, in the cycle after the source is set pending, and the bench sweeps every source against every selector value to catch this. A pending bit that is lost, stuck or wrongly raised appears in the bitmap read on the very next cycle, because every set, clear and edge test reads the bitmap back straight away. A field stored in the wrong place shows up as a mismatch when the written configuration value is read back.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int SEL_W = 4;
    localparam int TAG_W = 23;

    // Bit positions of the fields inside a configuration word.
    localparam int SEL_LSB = 0;
    localparam int TAG_LSB = 8;
    localparam int EN_BIT  = 31;

    typedef struct packed {
        logic             en;
        logic [TAG_W-1:0] tag;
        logic [SEL_W-1:0] sel;
    } src_cfg_t;

    function automatic src_cfg_t cfg_from_word(input logic [63:0] w);
        src_cfg_t c;
        c.en  = w[EN_BIT];
        c.tag = w[TAG_LSB +: TAG_W];
        c.sel = w[SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [63:0] cfg_to_word(input src_cfg_t c);
        logic [63:0] w;
        w = '0;
        w[EN_BIT]             = c.en;
        w[TAG_LSB +: TAG_W]   = c.tag;
        w[SEL_LSB +: SEL_W]   = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_line_route.sv
module irq_line_route #(
    parameter int NUM_SRC = 32,
    parameter int SEL_W   = 4,
    parameter int LINE    = 0
) (
    input  logic [NUM_SRC-1:0]       active,
    input  logic [NUM_SRC*SEL_W-1:0] sel_flat,
    output logic                     hit
);
    always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (active[s] && (sel_flat[s*SEL_W +: SEL_W] == SEL_W'(LINE)))
                hit = 1'b1;
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_HW    = 16,
    parameter int NUM_LINES = 5,
    parameter int ADDR_W    = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HW-1:0]    hw_irq,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_out
);
    localparam int WIDX_W   = ADDR_W - 3;
    localparam int IDX_PEND = NUM_SRC;
    localparam int IDX_SET  = NUM_SRC + 1;
    localparam int IDX_CLR  = NUM_SRC + 2;

    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0] cfg;
        logic     [NUM_SRC-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    logic [WIDX_W-1:0]        widx;
    logic [NUM_HW-1:0]        hw_rise;
    logic [NUM_SRC-1:0]       hw_ext;
    logic [NUM_SRC-1:0]       set_mask, clr_mask;
    logic [NUM_SRC-1:0]       active;
    logic [NUM_SRC*SEL_W-1:0] sel_flat;
    logic [NUM_SRC-1:0]       pend_q;

    assign widx   = bus_addr[ADDR_W-1:3];
    assign pend_q = st_q.pend;

    irq_edge_detect #(.W(NUM_HW)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (hw_irq),
        .rise  (hw_rise)
    );

    always_comb begin
        hw_ext             = '0;
        hw_ext[NUM_HW-1:0] = hw_rise;
    end

    // Next-state: configuration writes and pending update.
    always_comb begin
        st_d     = st_q;
        set_mask = '0;
        clr_mask = '0;
        if (bus_wr) begin
            if (widx == WIDX_W'(IDX_SET)) set_mask = bus_wdata[NUM_SRC-1:0];
            if (widx == WIDX_W'(IDX_CLR)) clr_mask = bus_wdata[NUM_SRC-1:0];
            for (int s = 0; s < NUM_SRC; s++) begin
                if (widx == WIDX_W'(s)) st_d.cfg[s] = cfg_from_word(bus_wdata);
            end
        end
        // Set and hardware edges are applied after the clear so they win.
        st_d.pend = (st_q.pend & ~clr_mask) | set_mask | hw_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (widx == WIDX_W'(s)) bus_rdata = cfg_to_word(st_q.cfg[s]);
        end
        if (widx == WIDX_W'(IDX_PEND)) bus_rdata[NUM_SRC-1:0] = st_q.pend;
    end

    // Routing network.
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            active[s]                   = st_q.pend[s] & st_q.cfg[s].en;
            sel_flat[s*SEL_W +: SEL_W]  = st_q.cfg[s].sel;
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irq_line_route #(
            .NUM_SRC (NUM_SRC),
            .SEL_W   (SEL_W),
            .LINE    (l)
        ) route_i (
            .active   (active),
            .sel_flat (sel_flat),
            .hit      (irq_out[l])
        );
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC   = 32,
    parameter int NUM_HW    = 16,
    parameter int NUM_LINES = 5,
    parameter int ADDR_W    = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_HW-1:0]    hw_irq,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [63:0]          bus_wdata,
    input logic [NUM_SRC-1:0]   pend_q,
    input logic [NUM_LINES-1:0] irq_out
);
    localparam int WIDX_W = ADDR_W - 3;

    logic [WIDX_W-1:0]  widx;
    logic               is_set, is_clr;
    logic [NUM_HW-1:0]  hw_last;
    logic [NUM_SRC-1:0] rise_ext;

    assign widx   = bus_addr[ADDR_W-1:3];
    assign is_set = bus_wr && (widx == WIDX_W'(NUM_SRC + 1));
    assign is_clr = bus_wr && (widx == WIDX_W'(NUM_SRC + 2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hw_last <= '0;
        else        hw_last <= hw_irq;
    end

    always_comb begin
        rise_ext             = '0;
        rise_ext[NUM_HW-1:0] = hw_irq & ~hw_last;
    end

    a_r4_set_effective: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> ((pend_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    a_r5_clear_effective: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((pend_q & $past(bus_wdata[NUM_SRC-1:0] & ~rise_ext)) == '0));

    a_r5_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !is_clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_ext) |=> ((pend_q & $past(rise_ext)) == $past(rise_ext)));

    a_r8_soft_only_by_set: assert property (@(posedge clk) disable iff (!rst_n)
        !is_set |=> ((pend_q[NUM_SRC-1:NUM_HW] & ~$past(pend_q[NUM_SRC-1:NUM_HW])) == '0));

    a_r9_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (irq_out == '0));
endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_HW    (NUM_HW),
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_irq    (hw_irq),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .irq_out   (irq_out)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
    localparam int NSRC = 32;
    localparam int NHW  = 16;
    localparam int NLN  = 5;
    localparam int AW   = 9;
    localparam logic [AW-1:0] A_PEND = 9'h100;
    localparam logic [AW-1:0] A_SET  = 9'h108;
    localparam logic [AW-1:0] A_CLR  = 9'h110;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NHW-1:0] hw_irq = '0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic [NLN-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_router #(.NUM_SRC(NSRC), .NUM_HW(NHW), .NUM_LINES(NLN), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [63:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < NSRC; s++) begin
            rd(AW'(s*8), v);
            chk("R1 cfg zero", v, 64'h0);
        end
        rd(A_PEND, v);
        chk("R1 pending zero", v, 64'h0);
        chk("R1 lines low", 64'(irq_out), 64'h0);

        // R2: field layout readback
        wr(AW'(9*8), 64'hFFFF_FFFF_FFFF_FFFF);
        rd(AW'(9*8), v);
        chk("R2 cfg readback mask", v, 64'h0000_0000_FFFF_FF0F);
        wr(AW'(9*8), 64'h0);

        // R4/R3: set with zero bits having no effect
        wr(A_SET, 64'h0);
        rd(A_PEND, v);
        chk("R4 zero mask no effect", v, 64'h0);
        wr(A_SET, 64'h8001_0400);
        rd(A_PEND, v);
        chk("R3 R4 set mask visible", v, 64'h8001_0400);
        wr(A_CLR, 64'h0000_0400);
        rd(A_PEND, v);
        chk("R5 clear one bit", v, 64'h8001_0000);
        wr(A_CLR, 64'h0);
        rd(A_PEND, v);
        chk("R5 zero clear no effect", v, 64'h8001_0000);

        // R12: writes to read-only pending and unmapped addresses
        wr(A_PEND, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(9'h118, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(9'h1F8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_PEND, v);
        chk("R12 pending unchanged", v, 64'h8001_0000);
        rd(9'h000, v);
        chk("R12 cfg0 unchanged", v, 64'h0);
        rd(9'h0F8, v);
        chk("R12 cfg31 unchanged", v, 64'h0);
        chk("R12 lines low", 64'(irq_out), 64'h0);
        wr(A_CLR, 64'hFFFF_FFFF);

        // R9/R10/R11: sweep every source against every selector value
        for (int s = 0; s < NSRC; s++) begin
            for (int sel = 0; sel < 16; sel++) begin
                logic [63:0] cw;
                logic [NLN-1:0] exp_l;
                cw = 64'h8000_0000 | (64'((s*7 + sel*13) & 32'h7F_FFFF) << 8) | 64'(sel);
                wr(AW'(s*8), cw);
                rd(AW'(s*8), v);
                chk("R11 tag readback", v, cw);
                wr(A_SET, 64'(1) << s);
                exp_l = (sel < NLN) ? NLN'(1 << sel) : '0;
                chk("R9 R10 R11 route line", 64'(irq_out), 64'(exp_l));
                wr(AW'(s*8), cw & ~64'h8000_0000);
                chk("R10 disabled silent", 64'(irq_out), 64'h0);
                wr(AW'(s*8), cw);
                wr(A_CLR, 64'(1) << s);
                chk("R9 cleared line low", 64'(irq_out), 64'h0);
            end
            wr(AW'(s*8), 64'h0);
        end

        // R9: two sources on different lines
        wr(AW'(2*8), 64'h8000_0001);
        wr(AW'(20*8), 64'h8000_0004);
        wr(A_SET, (64'(1) << 2) | (64'(1) << 20));
        chk("R9 two lines", 64'(irq_out), 64'h12);
        wr(A_CLR, 64'(1) << 2);
        chk("R9 one line left", 64'(irq_out), 64'h10);
        wr(A_CLR, 64'(1) << 20);

        // R6: edge latch, hold, no re-pend while high
        @(negedge clk); hw_irq[5] = 1'b1;
        @(negedge clk);
        rd(A_PEND, v);
        chk("R6 edge pends", v, 64'h20);
        hw_irq[5] = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_PEND, v);
        chk("R6 latched after drop", v, 64'h20);
        wr(A_CLR, 64'h20);
        rd(A_PEND, v);
        chk("R6 cleared", v, 64'h0);
        @(negedge clk); hw_irq[5] = 1'b1;
        @(negedge clk);
        wr(A_CLR, 64'h20);
        repeat (4) @(negedge clk);
        rd(A_PEND, v);
        chk("R6 steady high no re-pend", v, 64'h0);
        hw_irq[5] = 1'b0;

        // R7: edge and clear in the same cycle
        @(negedge clk);
        hw_irq[7] = 1'b1;
        bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 64'h80;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_PEND, v);
        chk("R7 edge beats clear", v, 64'h80);
        hw_irq[7] = 1'b0;
        wr(A_CLR, 64'hFFFF_FFFF);

        // R8: hardware activity never raises upper sources
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); hw_irq = '1;
            @(negedge clk); hw_irq = '0;
        end
        @(negedge clk);
        rd(A_PEND, v);
        p = v & 64'hFFFF_0000;
        chk("R8 upper untouched by hw", p, 64'h0);
        chk("R6 all hw pending", v & 64'hFFFF, 64'hFFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule